// File: doc/BRIEF.md
# Asynchronous Inverter Hazard Model

This block is a clocked behavioural model of a delay-insensitive NOT gate. It holds the last input level it received and the output level it last emitted. It classifies the pair into one of three modes. When the output equals the inverse of the input, the gate is stable. When it does not, an output update is pending and the gate is unstable. The third mode, hazard, is reached when the input moves back to a value that satisfies the inverse relation while an update is still pending. That is a failure, and the mode stays there until reset.

Input changes arrive as single-cycle valid strobes with a data bit. A free-running enable, `fire_en_i`, stands in for the unknown gate delay. A pending update is emitted only in a cycle where the enable is high and no input arrives, so each cycle uses at most one channel. Once the model has failed, each enable pulse emits an output that is the inverse of the previous one, which stands in for arbitrary values. The mode and a sticky failure flag are brought out so that a surrounding environment can be checked for hazard-free composition.

Top module: `inv_hazard_model`

## Requirements
- R1: After reset, the held input level is 0, the output is 1, the mode is STABLE (2'b00), `out_valid_o` is low and `hazard_seen_o` is low.
- R2: The mode is encoded as STABLE=2'b00, UNSTABLE=2'b01 and HAZARD=2'b10, and 2'b11 never appears. Outside HAZARD, the mode is STABLE exactly when `out_data_o` differs from `in_level_o`.
- R3: In STABLE, an accepted input that makes the output equal to the input moves the mode to UNSTABLE on the next cycle. An input equal to the held level leaves the mode STABLE.
- R4: In UNSTABLE, a cycle with `fire_en_i` high and `in_valid_i` low produces a one-cycle `out_valid_o` on the next cycle. That cycle carries `out_data_o` equal to the inverse of the held input, and the mode returns to STABLE.
- R5: In STABLE, `fire_en_i` has no effect: no `out_valid_o` appears and `out_data_o` keeps its value.
- R6: In UNSTABLE, an input that still leaves the output equal to the input keeps the mode UNSTABLE.
- R7: In UNSTABLE, an input that makes the output the inverse of the input moves the mode to HAZARD on the next cycle, and `hazard_seen_o` rises in that same cycle.
- R8: When `in_valid_i` and `fire_en_i` are both high, only the input is taken. No `out_valid_o` follows on the next cycle.
- R9: HAZARD is left only by reset. In HAZARD, each cycle with `fire_en_i` high and `in_valid_i` low emits `out_valid_o` with `out_data_o` inverted from its previous value.
- R10: `hazard_seen_o` stays high once set and is cleared only by reset.
- R11: Composed with a four-phase environment, the mode never reaches HAZARD. The environment sends a level and waits until the output is its inverse before it sends the opposite level. This holds for any pattern of send opportunities and `fire_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input channel strobe |
| in_data_i | input | 1 | Input level carried by the strobe |
| fire_en_i | input | 1 | Delay enable; permits one pending output update |
| out_valid_o | output | 1 | Output channel strobe, one cycle per update |
| out_data_o | output | 1 | Current output level |
| in_level_o | output | 1 | Last input level received |
| mode_o | output | 2 | Current mode (STABLE/UNSTABLE/HAZARD) |
| hazard_seen_o | output | 1 | Sticky failure flag |

## Verification
On every cycle the assertions check the following: the mode encoding is legal, the stable/unstable classification matches the relation between output and held input, HAZARD absorbs, the failure flag is sticky, and no output strobe follows an input cycle. They also check that an update out of UNSTABLE lands in STABLE with the inverted input, and that an input restoring the relation from UNSTABLE leads to HAZARD. Only the directed scenarios show the following: the exact reset values, that the enable has no effect while STABLE, the alternating values emitted after failure, and that reset clears the failure. The composition scenario alone shows that a correctly sequenced environment never drives the gate into HAZARD.

// File: rtl/inv_hazard_pkg.sv
package inv_hazard_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_STABLE   = 2'b00,
    MODE_UNSTABLE = 2'b01,
    MODE_HAZARD   = 2'b10
  } gate_mode_e;

  // gate relation holds when output is the inverse of input
  function automatic logic relation_ok(input logic in_lvl, input logic out_lvl);
    return out_lvl == ~in_lvl;
  endfunction
endpackage

// File: rtl/inv_in_reg.sv
module inv_in_reg #(
  parameter logic RESET_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic data_i,
  output logic level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_o <= RESET_LVL;
    else if (take_i) level_o <= data_i;
  end
endmodule

// File: rtl/inv_mode_fsm.sv
module inv_mode_fsm
  import inv_hazard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic       in_data_i,
  input  logic       fire_en_i,
  input  logic       out_lvl_i,
  output gate_mode_e mode_o,
  output gate_mode_e mode_next_o,
  output logic       fire_take_o
);
  gate_mode_e mode_q, mode_d;
  logic       new_ok;

  assign new_ok = relation_ok(in_data_i, out_lvl_i);
  // input channel wins; an output step only happens in an input-free cycle
  assign fire_take_o = fire_en_i && !in_valid_i && (mode_q != MODE_STABLE);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_STABLE: begin
        if (in_valid_i && !new_ok) mode_d = MODE_UNSTABLE;
      end
      MODE_UNSTABLE: begin
        if (in_valid_i) begin
          if (new_ok) mode_d = MODE_HAZARD;
        end else if (fire_en_i) begin
          mode_d = MODE_STABLE;
        end
      end
      MODE_HAZARD: mode_d = MODE_HAZARD;
      default:     mode_d = MODE_HAZARD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STABLE;
    else         mode_q <= mode_d;
  end

  assign mode_o      = mode_q;
  assign mode_next_o = mode_d;
endmodule

// File: rtl/inv_out_reg.sv
module inv_out_reg
  import inv_hazard_pkg::*;
#(
  parameter logic RESET_LVL = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_take_i,
  input  gate_mode_e mode_i,
  input  logic       in_lvl_i,
  output logic       out_lvl_o,
  output logic       out_valid_o
);
  logic out_d;

  // failed gate: alternate levels to model arbitrary output
  always_comb begin
    out_d = out_lvl_o;
    if (fire_take_i) begin
      if (mode_i == MODE_HAZARD) out_d = ~out_lvl_o;
      else                       out_d = ~in_lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_lvl_o   <= RESET_LVL;
      out_valid_o <= 1'b0;
    end else begin
      out_lvl_o   <= out_d;
      out_valid_o <= fire_take_i;
    end
  end
endmodule

// File: rtl/inv_fail_flag.sv
module inv_fail_flag
  import inv_hazard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  gate_mode_e mode_next_i,
  output logic       seen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          seen_o <= 1'b0;
    else if (mode_next_i == MODE_HAZARD)  seen_o <= 1'b1;
  end
endmodule

// File: rtl/inv_hazard_model.sv
module inv_hazard_model
  import inv_hazard_pkg::*;
#(
  parameter logic RESET_IN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_data_i,
  input  logic              fire_en_i,
  output logic              out_valid_o,
  output logic              out_data_o,
  output logic              in_level_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              hazard_seen_o
);
  localparam logic RESET_OUT = ~RESET_IN;

  gate_mode_e mode_q, mode_d;
  logic       fire_take;
  logic       in_lvl, out_lvl;

  inv_in_reg #(.RESET_LVL(RESET_IN)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (in_valid_i),
    .data_i  (in_data_i),
    .level_o (in_lvl)
  );

  inv_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .fire_en_i   (fire_en_i),
    .out_lvl_i   (out_lvl),
    .mode_o      (mode_q),
    .mode_next_o (mode_d),
    .fire_take_o (fire_take)
  );

  inv_out_reg #(.RESET_LVL(RESET_OUT)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_take_i (fire_take),
    .mode_i      (mode_q),
    .in_lvl_i    (in_lvl),
    .out_lvl_o   (out_lvl),
    .out_valid_o (out_valid_o)
  );

  inv_fail_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_next_i (mode_d),
    .seen_o      (hazard_seen_o)
  );

  assign out_data_o = out_lvl;
  assign in_level_o = in_lvl;
  assign mode_o     = mode_q;
endmodule

// File: rtl/inv_hazard_checker.sv
module inv_hazard_checker
  import inv_hazard_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_data_i,
  input logic              fire_en_i,
  input logic              out_valid_o,
  input logic              out_data_o,
  input logic              in_level_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              hazard_seen_o
);
  assert_legal_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  assert_stable_rel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STABLE) |-> (out_data_o != in_level_o));

  assert_unstable_rel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_UNSTABLE) |-> (out_data_o == in_level_o));

  assert_update_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_UNSTABLE && fire_en_i && !in_valid_i)
      |=> (out_valid_o && mode_o == MODE_STABLE && out_data_o == ~in_level_o));

  assert_restore_fails_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_UNSTABLE && in_valid_i && in_data_i != out_data_o)
      |=> (mode_o == MODE_HAZARD && hazard_seen_o));

  assert_input_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> !out_valid_o);

  assert_hazard_absorbs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_HAZARD) |=> (mode_o == MODE_HAZARD));

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_seen_o |=> hazard_seen_o);

  assert_quiet_output_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

bind inv_hazard_model inv_hazard_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_data_i     (in_data_i),
  .fire_en_i     (fire_en_i),
  .out_valid_o   (out_valid_o),
  .out_data_o    (out_data_o),
  .in_level_o    (in_level_o),
  .mode_o        (mode_o),
  .hazard_seen_o (hazard_seen_o)
);

// File: tb/inv_hazard_model_bench.sv
module inv_hazard_model_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_data_i = 1'b0;
  logic       fire_en_i = 1'b0;
  logic       out_valid_o, out_data_o, in_level_o, hazard_seen_o;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [1:0] ST = 2'b00, UN = 2'b01, HZ = 2'b10;

  always #5 clk_i = ~clk_i;

  inv_hazard_model u_inv_hazard_model (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid_i),
    .in_data_i     (in_data_i),
    .fire_en_i     (fire_en_i),
    .out_valid_o   (out_valid_o),
    .out_data_o    (out_data_o),
    .in_level_o    (in_level_o),
    .mode_o        (mode_o),
    .hazard_seen_o (hazard_seen_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, result visible at next negedge
  task automatic cyc(input logic v, input logic d, input logic f);
    in_valid_i = v;
    in_data_i  = d;
    fire_en_i  = f;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    fire_en_i  = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    fire_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "mode", mode_o, ST);
    chk("R1", "out", out_data_o, 1);
    chk("R1", "in", in_level_o, 0);
    chk("R1", "valid", out_valid_o, 0);
    chk("R1", "hazard", hazard_seen_o, 0);
  endtask

  task automatic t_stable_idle();
    do_reset();
    cyc(1, 0, 0);
    chk("R3", "same level keeps stable", mode_o, ST);
    cyc(0, 0, 1);
    chk("R5", "fire in stable valid", out_valid_o, 0);
    chk("R5", "fire in stable out", out_data_o, 1);
    chk("R5", "fire in stable mode", mode_o, ST);
  endtask

  task automatic t_update();
    do_reset();
    cyc(1, 1, 0);
    chk("R3", "break relation", mode_o, UN);
    chk("R2", "unstable out==in", out_data_o, in_level_o);
    cyc(0, 0, 1);
    chk("R4", "valid", out_valid_o, 1);
    chk("R4", "data", out_data_o, 0);
    chk("R4", "mode", mode_o, ST);
    cyc(0, 0, 0);
    chk("R4", "single pulse", out_valid_o, 0);
  endtask

  task automatic t_priority();
    do_reset();
    cyc(1, 1, 0);
    cyc(1, 1, 1);
    chk("R8", "no valid with input", out_valid_o, 0);
    chk("R6", "still unstable", mode_o, UN);
    chk("R8", "out held", out_data_o, 1);
    cyc(0, 0, 1);
    chk("R4", "deferred update", out_valid_o, 1);
    chk("R4", "deferred data", out_data_o, 0);
    chk("R2", "stable out!=in", out_data_o != in_level_o, 1);
  endtask

  task automatic t_hazard();
    do_reset();
    cyc(1, 1, 0);
    cyc(1, 0, 0);
    chk("R7", "mode", mode_o, HZ);
    chk("R7", "flag", hazard_seen_o, 1);
    cyc(0, 0, 1);
    chk("R9", "valid1", out_valid_o, 1);
    chk("R9", "toggle1", out_data_o, 0);
    cyc(0, 0, 1);
    chk("R9", "toggle2", out_data_o, 1);
    cyc(1, 1, 1);
    chk("R9", "input has priority", out_valid_o, 0);
    chk("R9", "absorbing", mode_o, HZ);
    repeat (4) cyc(0, 0, 0);
    chk("R10", "sticky", hazard_seen_o, 1);
    chk("R9", "still hazard", mode_o, HZ);
    do_reset();
    chk("R10", "cleared", hazard_seen_o, 0);
    chk("R1", "mode after reset", mode_o, ST);
  endtask

  task automatic t_compose();
    logic env_val = 1'b0;
    bit   need_send = 1'b1;
    int   hs = 0;
    int   bad = 0;
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      bit send = need_send && ($urandom_range(0, 1) == 1);
      in_valid_i = send;
      in_data_i  = env_val;
      fire_en_i  = ($urandom_range(0, 2) == 0);
      if (send) need_send = 1'b0;
      @(negedge clk_i);
      if (mode_o == HZ) bad++;
      if (!need_send && out_data_o == ~env_val) begin
        env_val   = ~env_val;
        need_send = 1'b1;
        hs++;
      end
    end
    in_valid_i = 1'b0;
    fire_en_i  = 1'b0;
    chk("R11", "hazard cycles", bad, 0);
    chk("R11", "handshakes progressed", hs > 100, 1);
    chk("R11", "flag clear", hazard_seen_o, 0);
  endtask

  initial begin
    t_reset();
    t_stable_idle();
    t_update();
    t_priority();
    t_hazard();
    t_compose();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule